// File: doc/BRIEF.md
# Ethernet PHY Mode Resolution and Carrier-Sense Logic

This block is the digital mode-control slice of a 10/100 Ethernet PHY. It works out which duplex and speed are in effect. Each one comes either from a forced control-register bit or from the result handed over by an external negotiation engine. A single selector decides which of the two sources applies. The effective mode is held in registers and reported on two status outputs.

From the effective mode and the live line signals, the block builds the registered carrier-sense (`crs`) and collision (`col`) outputs. Carrier sense is the receive carrier ORed with an echo of transmit enable. That echo is gated off by full duplex, collision, link failure, a transmit-disable bit, a dedicated echo-disable bit, and, only at 10 Mbps, jabber.

Two active-low indicator pins can each be pointed at duplex, speed, link or a constant-off level through a 2-bit select field.

Top module: `phy_mode_ctl`

## Requirements
- R1: When `auto_sel` is 1, `stat_fdx`/`stat_100` follow `neg_fdx`/`neg_100`. When it is 0, they follow `force_fdx`/`force_100`. The status outputs update one clock after the inputs change.
- R2: `crs` is a register holding the OR of `rx_crs` and the gated transmit echo. It reflects its inputs one clock later.
- R3: The echo copies `tx_en` onto `crs` for as long as `tx_en` is high, provided the effective mode is half duplex, `link_up`=1, `tx_disable`=0, `echo_disable`=0, there is no collision, and the mode is not 10 Mbps with `jabber`=1.
- R4: In full duplex, `col` stays 0 and the echo is off, so `crs` follows only `rx_crs`.
- R5: With `link_up`=0 the echo is off and `col` stays 0.
- R6: With `tx_disable`=1 the echo is off.
- R7: With `echo_disable`=1 the echo is off unconditionally.
- R8: At 10 Mbps (`stat_100`=0), `jabber`=1 turns the echo off. At 100 Mbps, `jabber` has no effect on `crs`.
- R9: `col` is a register set to 1 exactly when the mode is half duplex and `tx_en`, `rx_crs` and `link_up` are all 1. It updates one clock after its inputs.
- R10: Indicator i is selected by `led_sel[2i+1:2i]` with the codes 00=duplex (low in full duplex), 01=speed (low at 100 Mbps), 10=link (low while `link_up`=1) and 11=off (constant high). `led_n` is registered. It updates one clock after `stat_*` or `link_up` change, so it updates two clocks after a mode-input change.
- R11: During and right after synchronous reset: `crs`=0, `col`=0, `stat_fdx`=0, `stat_100`=0, and every `led_n` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_sel | input | 1 | 1: use negotiated mode, 0: use forced bits |
| force_fdx | input | 1 | Forced duplex bit (1 = full) |
| force_100 | input | 1 | Forced speed bit (1 = 100 Mbps) |
| neg_fdx | input | 1 | Negotiated duplex (1 = full) |
| neg_100 | input | 1 | Negotiated speed (1 = 100 Mbps) |
| tx_en | input | 1 | Transmit enable |
| rx_crs | input | 1 | Receive carrier detected |
| link_up | input | 1 | Link good (0 = link-fail state) |
| jabber | input | 1 | Jabber detected |
| tx_disable | input | 1 | Transmit-disable configuration bit |
| echo_disable | input | 1 | Transmit-to-CRS echo disable bit |
| led_sel | input | NUM_LEDS*2 | Per-indicator source select |
| led_n | output | NUM_LEDS | Active-low indicator outputs |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |
| stat_fdx | output | 1 | Effective duplex status |
| stat_100 | output | 1 | Effective speed status |

## Verification
`crs` and `col` are due one clock after a change on the line signals. The status bits are due one clock after a mode input changes. Anything that depends on the mode (echo gating, indicator pins) is due two clocks after a mode-input change, because the mode register sits on the path.

The bench drives inputs on the falling edge and samples on a later falling edge. In the vector loop it waits three edges so every path has settled. The directed tests sample at exactly one and two edges, which shows that a result is neither early nor late.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;
  localparam int LED_SEL_W = 2;

  typedef enum logic [LED_SEL_W-1:0] {
    LED_DUPLEX = 2'b00,
    LED_SPEED  = 2'b01,
    LED_LINK   = 2'b10,
    LED_OFF    = 2'b11
  } led_src_e;

  typedef struct packed {
    logic fdx;
    logic spd100;
  } mode_t;
endpackage

// File: rtl/phy_mode_resolve.sv
module phy_mode_resolve
  import phy_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  auto_sel,
  input  mode_t forced,
  input  mode_t negotiated,
  output mode_t eff
);
  mode_t pick;

  always_comb begin
    pick = auto_sel ? negotiated : forced;
  end

  always_ff @(posedge clk) begin
    if (rst) eff <= '0;
    else     eff <= pick;
  end

  // R1: source selection lands one cycle later
  assert_mode_src_R1: assert property (@(posedge clk) disable iff (rst)
    auto_sel |=> (eff == $past(negotiated)));
  assert_mode_forced_R1: assert property (@(posedge clk) disable iff (rst)
    !auto_sel |=> (eff == $past(forced)));
endmodule

// File: rtl/phy_crs_gen.sv
module phy_crs_gen
  import phy_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_t mode,
  input  logic  tx_en,
  input  logic  rx_crs,
  input  logic  link_up,
  input  logic  jabber,
  input  logic  tx_disable,
  input  logic  echo_disable,
  output logic  crs,
  output logic  col
);
  logic col_now;
  logic jab_block;
  logic echo_ok;
  logic echo;

  always_comb begin
    col_now   = !mode.fdx && tx_en && rx_crs && link_up;
    jab_block = !mode.spd100 && jabber;
    echo_ok   = !mode.fdx && link_up && !tx_disable && !echo_disable
                && !col_now && !jab_block;
    echo      = tx_en && echo_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crs <= 1'b0;
      col <= 1'b0;
    end else begin
      crs <= rx_crs | echo;
      col <= col_now;
    end
  end

  // R4: full duplex never reports collision
  assert_fdx_no_col_R4: assert property (@(posedge clk) disable iff (rst)
    mode.fdx |=> !col);
  // R5: link fail with no carrier gives no carrier sense
  assert_linkdown_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!link_up && !rx_crs) |=> (!crs && !col));
  // R7: echo disable leaves only the receive carrier
  assert_echo_off_R7: assert property (@(posedge clk) disable iff (rst)
    (echo_disable && !rx_crs) |=> !crs);
  // R9: a collision always comes with carrier sense
  assert_col_has_crs_R9: assert property (@(posedge clk) disable iff (rst)
    col |-> crs);
endmodule

// File: rtl/phy_led_mux.sv
module phy_led_mux
  import phy_mode_pkg::*;
#(
  parameter int NUM_LEDS = 2,
  localparam int SEL_W   = NUM_LEDS * LED_SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    led_sel,
  input  mode_t               mode,
  input  logic                link_up,
  output logic [NUM_LEDS-1:0] led_n
);
  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    led_src_e src;
    logic     on;

    always_comb begin
      src = led_src_e'(led_sel[i*LED_SEL_W +: LED_SEL_W]);
      case (src)
        LED_DUPLEX: on = mode.fdx;
        LED_SPEED:  on = mode.spd100;
        LED_LINK:   on = link_up;
        default:    on = 1'b0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) led_n[i] <= 1'b1;
      else     led_n[i] <= ~on;
    end

    // R10: off code always yields a high pin
    assert_led_off_R10: assert property (@(posedge clk) disable iff (rst)
      (src == LED_OFF) |=> led_n[i]);
  end
endmodule

// File: rtl/phy_mode_ctl.sv
module phy_mode_ctl
  import phy_mode_pkg::*;
#(
  parameter int NUM_LEDS = 2,
  localparam int SEL_W   = NUM_LEDS * LED_SEL_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                auto_sel,
  input  logic                force_fdx,
  input  logic                force_100,
  input  logic                neg_fdx,
  input  logic                neg_100,
  input  logic                tx_en,
  input  logic                rx_crs,
  input  logic                link_up,
  input  logic                jabber,
  input  logic                tx_disable,
  input  logic                echo_disable,
  input  logic [SEL_W-1:0]    led_sel,
  output logic [NUM_LEDS-1:0] led_n,
  output logic                crs,
  output logic                col,
  output logic                stat_fdx,
  output logic                stat_100
);
  mode_t forced_m, neg_m, eff_m;

  always_comb begin
    forced_m = '{fdx: force_fdx, spd100: force_100};
    neg_m    = '{fdx: neg_fdx,   spd100: neg_100};
  end

  phy_mode_resolve u_resolve (
    .clk        (clk),
    .rst        (rst),
    .auto_sel   (auto_sel),
    .forced     (forced_m),
    .negotiated (neg_m),
    .eff        (eff_m)
  );

  phy_crs_gen u_crs (
    .clk          (clk),
    .rst          (rst),
    .mode         (eff_m),
    .tx_en        (tx_en),
    .rx_crs       (rx_crs),
    .link_up      (link_up),
    .jabber       (jabber),
    .tx_disable   (tx_disable),
    .echo_disable (echo_disable),
    .crs          (crs),
    .col          (col)
  );

  phy_led_mux #(.NUM_LEDS(NUM_LEDS)) u_led (
    .clk     (clk),
    .rst     (rst),
    .led_sel (led_sel),
    .mode    (eff_m),
    .link_up (link_up),
    .led_n   (led_n)
  );

  always_comb begin
    stat_fdx = eff_m.fdx;
    stat_100 = eff_m.spd100;
  end

  // R11: outputs idle right after reset
  assert_reset_idle_R11: assert property (@(posedge clk)
    $past(rst) |-> (!crs && !col && !stat_fdx && !stat_100 && (&led_n)));
endmodule

// File: tb/tb_phy_mode_ctl.sv
`timescale 1ns/1ps
module tb_phy_mode_ctl;
  localparam int NL = 2;
  logic clk = 1'b0, rst = 1'b1;
  logic auto_sel = 0, force_fdx = 0, force_100 = 0, neg_fdx = 0, neg_100 = 0;
  logic tx_en = 0, rx_crs = 0, link_up = 0, jabber = 0, tx_disable = 0, echo_disable = 0;
  logic [2*NL-1:0] led_sel = '1;
  logic [NL-1:0] led_n;
  logic crs, col, stat_fdx, stat_100;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_mode_ctl #(.NUM_LEDS(NL)) dut (.*);

  // vector: [19:16] requirement, [15:5] inputs
  // {auto,ffdx,f100,nfdx,n100,tx,rx,link,jab,txdis,echodis}, [4] spare,
  // [3:0] expected {crs,col,fdx,100}
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {4'd2,  11'b0_0_0_0_0_0_1_1_0_0_0, 1'b0, 4'b1_0_0_0}, // R2 carrier only
    {4'd3,  11'b0_0_0_0_0_1_0_1_0_0_0, 1'b0, 4'b1_0_0_0}, // R3 echo
    {4'd4,  11'b0_1_0_0_0_1_0_1_0_0_0, 1'b0, 4'b0_0_1_0}, // R4 no echo fdx
    {4'd4,  11'b0_1_0_0_0_1_1_1_0_0_0, 1'b0, 4'b1_0_1_0}, // R4 no col fdx
    {4'd9,  11'b0_0_0_0_0_1_1_1_0_0_0, 1'b0, 4'b1_1_0_0}, // R9 collision
    {4'd5,  11'b0_0_0_0_0_1_0_0_0_0_0, 1'b0, 4'b0_0_0_0}, // R5 link fail
    {4'd9,  11'b0_0_0_0_0_1_1_0_0_0_0, 1'b0, 4'b1_0_0_0}, // R9 no col w/o link
    {4'd6,  11'b0_0_0_0_0_1_0_1_0_1_0, 1'b0, 4'b0_0_0_0}, // R6 tx disable
    {4'd7,  11'b0_0_0_0_0_1_0_1_0_0_1, 1'b0, 4'b0_0_0_0}, // R7 echo disable
    {4'd8,  11'b0_0_0_0_0_1_0_1_1_0_0, 1'b0, 4'b0_0_0_0}, // R8 jabber 10M
    {4'd8,  11'b0_0_1_0_0_1_0_1_1_0_0, 1'b0, 4'b1_0_0_1}, // R8 jabber 100M
    {4'd1,  11'b1_0_0_1_1_1_0_1_0_0_0, 1'b0, 4'b0_0_1_1}, // R1 negotiated
    {4'd1,  11'b1_1_1_0_0_1_0_1_0_0_0, 1'b0, 4'b1_0_0_0}, // R1 ignores forced
    {4'd2,  11'b0_0_0_0_0_0_0_1_0_0_0, 1'b0, 4'b0_0_0_0}  // R2 idle
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R11 reset state
    check("R11 reset outputs", {crs, col, stat_fdx, stat_100, led_n}, {4'b0000, 2'b11});
    rst = 0;
    tick(1);
    check("R11 after release", {crs, col, stat_fdx, stat_100}, 4'b0000);

    for (int v = 0; v < NV; v++) begin
      {auto_sel, force_fdx, force_100, neg_fdx, neg_100, tx_en, rx_crs,
       link_up, jabber, tx_disable, echo_disable} = VEC[v][15:5];
      tick(3);
      check($sformatf("R%0d vector %0d", VEC[v][19:16], v),
            {crs, col, stat_fdx, stat_100}, VEC[v][3:0]);
    end

    // R2/R3 echo timing: exactly one clock
    tx_en = 1;
    tick(1);
    check("R3 echo after one clock", crs, 1'b1);
    tx_en = 0;
    tick(1);
    check("R2 echo drops after one clock", crs, 1'b0);

    // R9 collision timing
    tx_en = 1; rx_crs = 1;
    tick(1);
    check("R9 col after one clock", col, 1'b1);
    tx_en = 0; rx_crs = 0;
    tick(1);
    check("R9 col clears", col, 1'b0);

    // R1 status one clock after forced change
    force_fdx = 1;
    tick(1);
    check("R1 stat_fdx one clock", stat_fdx, 1'b1);

    // R10 indicators: LED0 duplex, LED1 speed
    led_sel = {2'b01, 2'b00};
    tick(2);
    check("R10 duplex low, speed high", led_n, 2'b10);
    force_100 = 1;
    tick(1);
    check("R10 speed not yet", led_n[1], 1'b1);
    tick(1);
    check("R10 speed low after two clocks", led_n[1], 1'b0);

    // R10 link and off
    led_sel = {2'b11, 2'b10};
    tick(1);
    check("R10 link low, off high", led_n, 2'b10);
    link_up = 0;
    tick(1);
    check("R10 link down high", led_n[0], 1'b1);

    // R4 fdx at 100M: echo still off, duplex identical at both speeds
    link_up = 1; tx_en = 1;
    tick(2);
    check("R4 fdx 100M no echo", {crs, col}, 2'b00);
    tx_en = 0;

    // R11 reset in mid-run
    rst = 1;
    tick(1);
    check("R11 reset again", {crs, col, stat_fdx, stat_100, led_n}, {4'b0000, 2'b11});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule